// File: doc/BRIEF.md
# Program Counter Write Resolver

This unit sits at the point where a processor retires a write to its program counter. The processor has two instruction-set states: a wide state with 32-bit instructions and a compact state with 16-bit instructions. Each PC write arrives with four things: the written value, a class code for the kind of instruction that made it, the current state and a flag-setting indicator. An exception return also carries the status word it restores. From these the unit works out the next fetch address and the next state, aligns the address for that state, and flags a target that cannot be aligned cleanly. All results are registered. A one-cycle redirect pulse tells the fetch side to take the new address.

Class codes, as a 3-bit field: 0 = exchange-capable write (register branch-exchange, PC load, pop, ordinary load-multiple); 1 = state-keeping branch (direct, compare-and-branch, table, handler, failed null check); 2 = immediate link-and-exchange (state toggle); 3 = compact register add/move to the PC; 4 = exception return; 5 = data-processing result (arithmetic, logical, shift, move); 6 and 7 are reserved. State output: 0 = wide, 1 = compact.

Top module: `pc_write_resolver`

## Requirements
- R1: While reset is held, next_pc is 0, next_compact is 0, unpred is 0 and redirect is 0.
- R2: redirect is 1 in the cycle after each rising clock edge that samples wr_valid=1 with a class from 0 to 5. It is 0 after any edge with wr_valid=0 or a class of 6 or 7. When no request is accepted, next_pc, next_compact and unpred keep their values.
- R3: Class 0 decodes the low bits of the value. If bit 0 is 1: compact state, bit 0 cleared, unpred 0. If bits 1:0 are 00: wide state, value unchanged, unpred 0. If bits 1:0 are 10: wide state, bits 1:0 cleared, unpred 1.
- R4: Class 1 keeps cur_compact as the next state, passes the value through unchanged and sets unpred to 0.
- R5: Class 2 inverts cur_compact, passes the value through unchanged and sets unpred to 0.
- R6: Class 3 selects compact state, clears bit 0 of the value and sets unpred to 0, whatever the current state.
- R7: Class 4 takes the next state from bit STATE_BIT (default 5) of status_word, where 1 means compact. For compact it clears bit 0 of the value; for wide it clears bits 1:0. unpred is 1 exactly when a cleared bit was 1.
- R8: Class 5 with cur_compact=0 and flag_set=0 decodes the value exactly as in R3.
- R9: Class 5 with cur_compact=1 or flag_set=1 keeps the current state. It clears bit 0 (compact) or bits 1:0 (wide), and sets unpred to 0.
- R10: With wr_valid=1, classes 6 and 7 leave next_pc, next_compact and unpred unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A PC write request is present |
| wr_value | input | AW | Value written to the PC |
| wr_class | input | 3 | Class code of the writing instruction |
| cur_compact | input | 1 | Current state, 1 = compact |
| flag_set | input | 1 | The writing instruction requests flag setting |
| status_word | input | SW | Status word restored by an exception return |
| next_pc | output | AW | Aligned next fetch address |
| next_compact | output | 1 | Next state, 1 = compact |
| redirect | output | 1 | One-cycle pulse: take next_pc |
| unpred | output | 1 | The target could not be aligned without dropping set bits |

## Verification
Every output is one register stage from the inputs. A request sampled on a rising edge therefore shows on next_pc, next_compact, unpred and redirect from that edge until the following one. The bench drives stimulus on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It then drives an idle cycle with changed data and samples again one edge later. That second sample confirms that the redirect pulse has dropped and that the results are held. The sweep covers every class, both states, both flag settings, all four low-bit patterns and both values of the status state bit.

// File: rtl/pcw_pkg.sv
`timescale 1ns/1ps
package pcw_pkg;
    localparam int CLS_W = 3;

    localparam logic [CLS_W-1:0] WC_INTERWORK   = 3'd0;
    localparam logic [CLS_W-1:0] WC_KEEP        = 3'd1;
    localparam logic [CLS_W-1:0] WC_TOGGLE      = 3'd2;
    localparam logic [CLS_W-1:0] WC_COMPACT_REG = 3'd3;
    localparam logic [CLS_W-1:0] WC_EXC_RETURN  = 3'd4;
    localparam logic [CLS_W-1:0] WC_DATAPROC    = 3'd5;

    // A class code the unit acts upon (6 and 7 are reserved)
    function automatic logic class_known(input logic [CLS_W-1:0] c);
        return c <= WC_DATAPROC;
    endfunction
endpackage

// File: rtl/pcw_interwork.sv
`timescale 1ns/1ps
// Decodes an exchange-capable target: low bits select state and alignment.
module pcw_interwork #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] value,
    output logic [AW-1:0] pc,
    output logic          to_compact,
    output logic          bad_align
);
    always_comb begin
        pc         = value;
        to_compact = 1'b0;
        bad_align  = 1'b0;
        if (value[0]) begin
            to_compact = 1'b1;
            pc[0]      = 1'b0;
        end else if (value[1]) begin
            bad_align = 1'b1;
            pc[1:0]   = 2'b00;
        end
    end
endmodule

// File: rtl/pcw_align.sv
`timescale 1ns/1ps
// Forces a target onto the boundary of a given state, reporting dropped ones.
module pcw_align #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] value,
    input  logic          compact,
    output logic [AW-1:0] pc,
    output logic          dropped
);
    always_comb begin
        pc = value;
        if (compact) begin
            pc[0]   = 1'b0;
            dropped = value[0];
        end else begin
            pc[1:0] = 2'b00;
            dropped = |value[1:0];
        end
    end
endmodule

// File: rtl/pc_write_resolver.sv
`timescale 1ns/1ps
module pc_write_resolver
    import pcw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SW        = 32,
    parameter int STATE_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [AW-1:0]     wr_value,
    input  logic [CLS_W-1:0]  wr_class,
    input  logic              cur_compact,
    input  logic              flag_set,
    input  logic [SW-1:0]     status_word,
    output logic [AW-1:0]     next_pc,
    output logic              next_compact,
    output logic              redirect,
    output logic              unpred
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic          compact;
        logic          unpred;
        logic          redirect;
    } res_t;

    res_t st_d, st_q;

    logic [AW-1:0] iw_pc;
    logic          iw_compact;
    logic          iw_bad;
    logic [AW-1:0] ret_pc;
    logic          ret_drop;
    logic [AW-1:0] cur_pc;
    logic          unused_cur_drop;
    logic          ret_compact;
    logic          unused_status;

    assign ret_compact   = status_word[STATE_BIT];
    assign unused_status = ^status_word;

    pcw_interwork #(.AW(AW)) u_iw (
        .value      (wr_value),
        .pc         (iw_pc),
        .to_compact (iw_compact),
        .bad_align  (iw_bad)
    );

    pcw_align #(.AW(AW)) u_align_ret (
        .value   (wr_value),
        .compact (ret_compact),
        .pc      (ret_pc),
        .dropped (ret_drop)
    );

    pcw_align #(.AW(AW)) u_align_cur (
        .value   (wr_value),
        .compact (cur_compact),
        .pc      (cur_pc),
        .dropped (unused_cur_drop)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        if (wr_valid && class_known(wr_class)) begin
            st_d.redirect = 1'b1;
            st_d.unpred   = 1'b0;
            case (wr_class)
                WC_INTERWORK: begin
                    st_d.pc      = iw_pc;
                    st_d.compact = iw_compact;
                    st_d.unpred  = iw_bad;
                end
                WC_KEEP: begin
                    st_d.pc      = wr_value;
                    st_d.compact = cur_compact;
                end
                WC_TOGGLE: begin
                    st_d.pc      = wr_value;
                    st_d.compact = !cur_compact;
                end
                WC_COMPACT_REG: begin
                    st_d.pc      = {wr_value[AW-1:1], 1'b0};
                    st_d.compact = 1'b1;
                end
                WC_EXC_RETURN: begin
                    st_d.pc      = ret_pc;
                    st_d.compact = ret_compact;
                    st_d.unpred  = ret_drop;
                end
                default: begin
                    if (!cur_compact && !flag_set) begin
                        st_d.pc      = iw_pc;
                        st_d.compact = iw_compact;
                        st_d.unpred  = iw_bad;
                    end else begin
                        st_d.pc      = cur_pc;
                        st_d.compact = cur_compact;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign next_pc      = st_q.pc;
    assign next_compact = st_q.compact;
    assign redirect     = st_q.redirect;
    assign unpred       = st_q.unpred;
endmodule

// File: rtl/pcw_checker.sv
`timescale 1ns/1ps
module pcw_checker
    import pcw_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SW        = 32,
    parameter int STATE_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [AW-1:0]     wr_value,
    input logic [CLS_W-1:0]  wr_class,
    input logic              cur_compact,
    input logic              flag_set,
    input logic [SW-1:0]     status_word,
    input logic [AW-1:0]     next_pc,
    input logic              next_compact,
    input logic              redirect,
    input logic              unpred
);
    AST_REDIRECT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_class <= WC_DATAPROC) |=> redirect); // R2
    AST_NO_REDIRECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (!redirect && $stable(next_pc) && $stable(next_compact))); // R2
    AST_IW_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_class == WC_INTERWORK && wr_value[1:0] == 2'b10)
        |=> (unpred && !next_compact && next_pc[1:0] == 2'b00)); // R3
    AST_TOGGLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_class == WC_TOGGLE) |=> (next_compact != $past(cur_compact))); // R5
    AST_COMPACT_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_class == WC_COMPACT_REG) |=> (next_compact && !next_pc[0] && !unpred)); // R6
    AST_EXC_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_class == WC_EXC_RETURN)
        |=> (next_compact == $past(status_word[STATE_BIT]))); // R7
    AST_DP_KEEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_class == WC_DATAPROC && (cur_compact || flag_set))
        |=> (next_compact == $past(cur_compact) && !unpred)); // R9
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_class > WC_DATAPROC)
        |=> ($stable(next_pc) && $stable(unpred) && !redirect)); // R10
endmodule

bind pc_write_resolver pcw_checker #(.AW(AW), .SW(SW), .STATE_BIT(STATE_BIT)) u_chk (.*);

// File: tb/sim_pc_write_resolver.sv
`timescale 1ns/1ps
module sim_pc_write_resolver;
    localparam int AW = 32;
    localparam int SW = 32;
    localparam int SB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_value = '0;
    logic [2:0]    wr_class = '0;
    logic          cur_compact = 1'b0;
    logic          flag_set = 1'b0;
    logic [SW-1:0] status_word = '0;
    logic [AW-1:0] next_pc;
    logic          next_compact;
    logic          redirect;
    logic          unpred;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] e_pc = '0;
    logic          e_cmp = 1'b0;
    logic          e_unp = 1'b0;

    always #2 clk = ~clk;

    pc_write_resolver #(.AW(AW), .SW(SW), .STATE_BIT(SB)) u0 (.*);

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Exchange-capable decode of R3 / R8
    task automatic iw_model(input logic [AW-1:0] v);
        e_pc = v; e_unp = 1'b0;
        if (v[0]) begin e_cmp = 1'b1; e_pc[0] = 1'b0; end
        else begin
            e_cmp = 1'b0;
            if (v[1]) begin e_unp = 1'b1; e_pc[1:0] = 2'b00; end
        end
    endtask

    task automatic model(input logic [2:0] c, input logic [AW-1:0] v, input logic cc,
                         input logic fs, input logic sbit, output string tag);
        case (c)
            3'd0: begin tag = "R3"; iw_model(v); end
            3'd1: begin tag = "R4"; e_pc = v; e_cmp = cc; e_unp = 1'b0; end
            3'd2: begin tag = "R5"; e_pc = v; e_cmp = !cc; e_unp = 1'b0; end
            3'd3: begin tag = "R6"; e_pc = v & ~32'd1; e_cmp = 1'b1; e_unp = 1'b0; end
            3'd4: begin
                tag = "R7"; e_cmp = sbit;
                e_pc  = sbit ? (v & ~32'd1) : (v & ~32'd3);
                e_unp = sbit ? v[0] : (|v[1:0]);
            end
            3'd5: begin
                if (!cc && !fs) begin tag = "R8"; iw_model(v); end
                else begin
                    tag = "R9"; e_cmp = cc; e_unp = 1'b0;
                    e_pc = cc ? (v & ~32'd1) : (v & ~32'd3);
                end
            end
            default: tag = "R10";
        endcase
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        chk("R1 pc", next_pc, '0);
        chk("R1 state", {31'd0, next_compact}, '0);
        chk("R1 unpred", {31'd0, unpred}, '0);
        chk("R1 redirect", {31'd0, redirect}, '0);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            for (int cc = 0; cc < 2; cc++) begin
                for (int fs = 0; fs < 2; fs++) begin
                    for (int lo = 0; lo < 4; lo++) begin
                        for (int sb = 0; sb < 2; sb++) begin
                            logic [AW-1:0] v;
                            v = (32'h8000_1230 + 32'h0101_0040 * c + 32'h10 * (cc*8 + fs*4 + sb))
                                & ~32'd3;
                            v = v | lo[AW-1:0];
                            wr_valid = 1'b1; wr_class = c[2:0]; wr_value = v;
                            cur_compact = cc[0]; flag_set = fs[0];
                            status_word = 32'h0000_01c0 ^ (sb[0] ? 32'h20 : 32'h0);
                            model(c[2:0], v, cc[0], fs[0], sb[0], tag);
                            @(posedge clk); @(negedge clk);
                            chk({tag, " pc"}, next_pc, e_pc);
                            chk({tag, " state"}, {31'd0, next_compact}, {31'd0, e_cmp});
                            chk({tag, " unpred"}, {31'd0, unpred}, {31'd0, e_unp});
                            chk("R2 redirect on request", {31'd0, redirect}, {31'd0, c < 6});
                            // idle cycle with disturbed inputs: pulse drops, results hold
                            wr_valid = 1'b0; wr_value = ~v; cur_compact = ~cc[0];
                            status_word = ~status_word;
                            @(posedge clk); @(negedge clk);
                            chk("R2 hold pc", next_pc, e_pc);
                            chk("R2 hold state", {31'd0, next_compact}, {31'd0, e_cmp});
                            chk("R2 hold unpred", {31'd0, unpred}, {31'd0, e_unp});
                            chk("R2 idle redirect", {31'd0, redirect}, '0);
                        end
                    end
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule